// File: doc/BRIEF.md
# Flash Checksum Read Engine with Timing Calibration

This block is the read-timing calibration and checksum part of a serial flash controller's DMA unit. Software programs a flash start address, a byte length and a control word through a small register port. A control word that enables a checksum pass starts the engine. If that control word also asks for calibration, the engine first applies the requested clock divisor and read delay. It writes the divisor into the clock field of the chip-select-0 control register. For the fastest divisors it also writes the delay into the matching nibble of the shared read-timing register. After that it reads flash words one at a time and adds them into a checksum.

Software uses this to sweep clock and delay settings. Each setting runs the same checksum pass, and the sums are compared to find the read timing that returns stable data. The divisor arrives as a scrambled 4-bit select code, which the engine turns into a divisor from 1 to 16. The timing register has one delay slot per divisor, and every chip select shares it.

The flash read port uses a request/valid handshake. The engine raises `rd_req` with `rd_addr`. It holds both steady until the flash side returns `rd_valid` with the word, so the flash side applies back-pressure simply by delaying `rd_valid`. Control and status pins are plain levels.

Top module: `dma_cal_engine`

Register map on `cfg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | control | write and read |
| 1 | flash address | write and read |
| 2 | length | write and read |
| 3 | checksum | read only |
| 4 | timing | write and read |
| 5 | chip-select-0 control | write and read |

Control word bits:

| Bits | Meaning |
|---|---|
| 0 | enable |
| 1 | write direction |
| 2 | checksum |
| 3 | calibrate |
| [7:4] | clock-select code |
| [11:8] | delay value |
| 31 | done, read only |

## Requirements
- R1: After reset, every register reads 0, `rd_req` is 0 and `done` is 0.
- R2: On calibration, the code in control [7:4] is decoded into a divisor. Codes 15,7,14,6,13,5,12,4,11,3,10,2,9,1,8,0 give divisors 1,2,...,16 in that order. Chip-select-0 bits [11:8] receive the divisor modulo 16, so divisor 16 is written as 0. All other bits of that register keep their value.
- R3: On calibration with divisor d in 1..5, timing bits [4d-1:4d-4] receive the delay from control [11:8], and the other timing bits keep their value. With d of 6 or more, the timing register is unchanged.
- R4: Without the calibrate bit, the checksum pass runs and neither the timing register nor the chip-select-0 register changes.
- R5: The checksum is cleared at start. Each returned word is added modulo 2^32, the address advances by 4, and the length decreases by 4 (saturating at 0). The pass issues ceil(length/4) reads from consecutive addresses, starting at the programmed address.
- R6: While `rd_req` is high and `rd_valid` is low, `rd_req` stays high and `rd_addr` does not change in the next cycle.
- R7: At the end of a pass, `done` (also control bit 31) is set and stays set, and control bit 0 reads 0. A later control write clears `done`.
- R8: A control write with enable, checksum and write direction all set starts nothing: no read is issued, `done` stays 0 and the timing register is unchanged.
- R9: A pass started with length 0 issues no reads, still applies the calibration updates, and sets `done`.
- R10: Register writes that arrive while a pass is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_wr | input | 1 | register write strobe |
| cfg_addr | input | 3 | register address |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data for cfg_addr, combinational |
| rd_req | output | 1 | flash read request |
| rd_addr | output | 32 | flash read byte address |
| rd_valid | input | 1 | flash read data valid, completes the request |
| rd_data | input | 32 | flash read word |
| done | output | 1 | sticky pass-complete flag |

## Verification
A wrong divisor decode or a wrong nibble position shows up as a wrong value in the timing or chip-select-0 readback. It is visible in the first cycle after the start write, before the first read request. A wrong step, length or accumulation state shows up as a wrong read address or a wrong request count within one handshake. It also leaves a checksum mismatch that can be read once `done` rises. A lost hold on the request shows up in the very cycle the address moves while `rd_valid` is still low.

// File: rtl/dma_cal_pkg.sv
package dma_cal_pkg;
  localparam int DATA_W = 32;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_READ = 2'd2
  } eng_state_t;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 3'd0,
    RA_FADDR  = 3'd1,
    RA_LEN    = 3'd2,
    RA_SUM    = 3'd3,
    RA_TIMING = 3'd4,
    RA_CS0    = 3'd5
  } reg_addr_t;

  localparam int CB_EN    = 0;
  localparam int CB_WR    = 1;
  localparam int CB_CKSUM = 2;
  localparam int CB_CAL   = 3;
  localparam int CB_CODE  = 4;
  localparam int CB_DLY   = 8;
  localparam int CB_DONE  = 31;
  localparam int CTRL_KEEP_W = 12;
endpackage

// File: rtl/dma_cal_divdec.sv
module dma_cal_divdec #(
  parameter int CODE_W = 4,
  localparam int DIV_W = CODE_W + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  divisor
);
  localparam int HALF = 1 << (CODE_W - 1);
  localparam int TOP  = (1 << CODE_W) - 1;

  // Upper half of the code space gives odd divisors (counting down),
  // lower half gives even divisors.
  logic [DIV_W-1:0] code_x;
  logic             upper;

  always_comb begin
    code_x = {1'b0, code};
    upper  = code_x >= DIV_W'(HALF);
    if (upper)
      divisor = DIV_W'((DIV_W'(TOP) - code_x) << 1) + DIV_W'(1);
    else
      divisor = DIV_W'((DIV_W'(HALF - 1) - code_x) << 1) + DIV_W'(2);
  end
endmodule

// File: rtl/dma_cal_patch.sv
module dma_cal_patch #(
  parameter int REG_W     = 32,
  parameter int SLOT_W    = 4,
  parameter int SLOTS     = 5,
  parameter int DIV_W     = 5,
  parameter int CLK_LSB   = 8,
  parameter int CLK_W     = 4
) (
  input  logic [REG_W-1:0]  timing_in,
  input  logic [REG_W-1:0]  cs0_in,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [SLOT_W-1:0] delay,
  output logic [REG_W-1:0]  timing_out,
  output logic [REG_W-1:0]  cs0_out
);
  localparam int ALL_SLOTS = REG_W / SLOT_W;

  genvar g;
  generate
    for (g = 0; g < ALL_SLOTS; g++) begin : g_slot
      if (g < SLOTS) begin : g_tunable
        assign timing_out[g*SLOT_W +: SLOT_W] =
          (divisor == DIV_W'(g + 1)) ? delay : timing_in[g*SLOT_W +: SLOT_W];
      end else begin : g_fixed
        assign timing_out[g*SLOT_W +: SLOT_W] = timing_in[g*SLOT_W +: SLOT_W];
      end
    end
    if (ALL_SLOTS * SLOT_W < REG_W) begin : g_tail
      assign timing_out[REG_W-1:ALL_SLOTS*SLOT_W] = timing_in[REG_W-1:ALL_SLOTS*SLOT_W];
    end
  endgenerate

  always_comb begin
    cs0_out = cs0_in;
    cs0_out[CLK_LSB +: CLK_W] = divisor[CLK_W-1:0];
  end
endmodule

// File: rtl/dma_cal_reader.sv
module dma_cal_reader
  import dma_cal_pkg::*;
#(
  parameter int W = 32,
  localparam int STEP = W / 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_addr,
  input  logic         load_len,
  input  logic [W-1:0] wdata,
  input  logic         start,
  input  logic         use_cal,
  output logic         cal_apply,
  output logic         finish,
  output logic         busy,
  output logic         rd_req,
  output logic [W-1:0] rd_addr,
  input  logic         rd_valid,
  input  logic [W-1:0] rd_data,
  output logic [W-1:0] len_q,
  output logic [W-1:0] sum_q
);
  eng_state_t state;
  logic [W-1:0] addr_q;
  logic         len_zero;

  assign len_zero  = (len_q == '0);
  assign cal_apply = (state == ST_CAL);
  assign finish    = (state == ST_READ) && len_zero;
  assign busy      = (state != ST_IDLE);
  assign rd_req    = (state == ST_READ) && !len_zero;
  assign rd_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      sum_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (load_addr) addr_q <= wdata;
          if (load_len)  len_q  <= wdata;
          if (start) begin
            sum_q <= '0;
            state <= use_cal ? ST_CAL : ST_READ;
          end
        end
        ST_CAL: state <= ST_READ;
        ST_READ: begin
          if (len_zero) begin
            state <= ST_IDLE;
          end else if (rd_valid) begin
            sum_q  <= sum_q + rd_data;
            addr_q <= addr_q + W'(STEP);
            len_q  <= (len_q > W'(STEP)) ? len_q - W'(STEP) : '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_cal_engine.sv
module dma_cal_engine
  import dma_cal_pkg::*;
#(
  parameter int W         = DATA_W,
  parameter int AW        = REG_AW,
  parameter int CODE_W    = 4,
  parameter int SLOTS     = 5,
  parameter int CLK_LSB   = 8,
  localparam int DIV_W    = CODE_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  output logic [W-1:0]  cfg_rdata,
  output logic          rd_req,
  output logic [W-1:0]  rd_addr,
  input  logic          rd_valid,
  input  logic [W-1:0]  rd_data,
  output logic          done
);
  logic [CTRL_KEEP_W-1:0] ctrl_q;
  logic [W-1:0] timing_q, cs0_q, len_q, sum_q;
  logic [W-1:0] timing_nx, cs0_nx;
  logic [DIV_W-1:0] divisor;
  logic wr_ok, wr_ctrl, start, cal_apply, finish, busy;

  assign wr_ok   = cfg_wr && !busy;
  assign wr_ctrl = wr_ok && (cfg_addr == AW'(RA_CTRL));
  assign start   = wr_ctrl && cfg_wdata[CB_EN] && cfg_wdata[CB_CKSUM] && !cfg_wdata[CB_WR];

  dma_cal_divdec #(.CODE_W(CODE_W)) u_dec (
    .code    (ctrl_q[CB_CODE +: CODE_W]),
    .divisor (divisor)
  );

  dma_cal_patch #(
    .REG_W(W), .SLOT_W(CODE_W), .SLOTS(SLOTS), .DIV_W(DIV_W),
    .CLK_LSB(CLK_LSB), .CLK_W(CODE_W)
  ) u_patch (
    .timing_in  (timing_q),
    .cs0_in     (cs0_q),
    .divisor    (divisor),
    .delay      (ctrl_q[CB_DLY +: CODE_W]),
    .timing_out (timing_nx),
    .cs0_out    (cs0_nx)
  );

  dma_cal_reader #(.W(W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_addr (wr_ok && (cfg_addr == AW'(RA_FADDR))),
    .load_len  (wr_ok && (cfg_addr == AW'(RA_LEN))),
    .wdata     (cfg_wdata),
    .start     (start),
    .use_cal   (cfg_wdata[CB_CAL]),
    .cal_apply (cal_apply),
    .finish    (finish),
    .busy      (busy),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .len_q     (len_q),
    .sum_q     (sum_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      timing_q <= '0;
      cs0_q    <= '0;
      done     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= cfg_wdata[CTRL_KEEP_W-1:0];
        done   <= 1'b0;
      end
      if (wr_ok && cfg_addr == AW'(RA_TIMING)) timing_q <= cfg_wdata;
      if (wr_ok && cfg_addr == AW'(RA_CS0))    cs0_q    <= cfg_wdata;
      if (cal_apply) begin
        timing_q <= timing_nx;
        cs0_q    <= cs0_nx;
      end
      if (finish) begin
        done          <= 1'b1;
        ctrl_q[CB_EN] <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      AW'(RA_CTRL): begin
        cfg_rdata[CTRL_KEEP_W-1:0] = ctrl_q;
        cfg_rdata[CB_DONE]         = done;
      end
      AW'(RA_FADDR):  cfg_rdata = rd_addr;
      AW'(RA_LEN):    cfg_rdata = len_q;
      AW'(RA_SUM):    cfg_rdata = sum_q;
      AW'(RA_TIMING): cfg_rdata = timing_q;
      AW'(RA_CS0):    cfg_rdata = cs0_q;
      default:        cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_cal_engine_chk.sv
module dma_cal_engine_chk #(
  parameter int W = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [AW-1:0] cfg_addr,
  input logic [W-1:0]  cfg_wdata,
  input logic          rd_req,
  input logic [W-1:0]  rd_addr,
  input logic          rd_valid,
  input logic          done,
  input logic          busy
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (!rd_req || rd_addr == $past(rd_addr) + W'(4)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req && !busy));

  // R8
  wr_dir_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_wr && cfg_addr == AW'(0) && cfg_wdata[1]) |=> !busy);

  // R10
  busy_ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cfg_wr && cfg_addr == AW'(0)) |=> !done || $past(rd_req) == 1'b0);
endmodule

bind dma_cal_engine dma_cal_engine_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_valid  (rd_valid),
  .done      (done),
  .busy      (busy)
);

// File: tb/tb_dma_cal_engine.sv
module tb_dma_cal_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dma_cal_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  localparam int CODE_ORDER [16] = '{15, 7, 14, 6, 13, 5, 12, 4, 11, 3, 10, 2, 9, 1, 8, 0};

  typedef struct packed {
    logic [3:0]  code;
    logic [3:0]  dly;
    logic        cal;
    logic [31:0] len;
    logic [31:0] base;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd15, 4'h9, 1'b1, 32'd16, 32'h0000_0100, 4'd0},
    '{4'd7,  4'h3, 1'b1, 32'd8,  32'h0000_2000, 4'd2},
    '{4'd13, 4'hA, 1'b1, 32'd12, 32'h0001_0040, 4'd1},
    '{4'd5,  4'h7, 1'b1, 32'd20, 32'hFFFF_FFF0, 4'd0},
    '{4'd0,  4'hF, 1'b1, 32'd4,  32'h0000_0800, 4'd3},
    '{4'd14, 4'h1, 1'b0, 32'd24, 32'h0000_3000, 4'd1},
    '{4'd8,  4'h6, 1'b1, 32'd6,  32'h0000_0010, 4'd3},
    '{4'd6,  4'hC, 1'b1, 32'd0,  32'h0000_0500, 4'd0}
  };

  localparam logic [31:0] TIM_INIT = 32'h8765_4321;
  localparam logic [31:0] CS0_INIT = 32'hA5A5_F5A5;

  // flash responder state
  int          lat_cfg = 0;
  int          served = 0;
  int          stab_err = 0;
  int          seq_err = 0;
  logic [31:0] next_exp = '0;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return a * 32'h0100_0193 + 32'hC0DE_1234;
  endfunction

  function automatic int div_of(input logic [3:0] c);
    for (int i = 0; i < 16; i++) if (CODE_ORDER[i] == int'(c)) return i + 1;
    return 0;
  endfunction

  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rst_n && rd_req) begin
        a = rd_addr;
        if (a != next_exp) seq_err++;
        next_exp = next_exp + 32'd4;
        for (int k = 0; k < lat_cfg; k++) begin
          @(negedge clk);
          if (!rd_req || rd_addr != a) stab_err++;
        end
        rd_valid = 1'b1;
        rd_data  = word_at(a);
        served++;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v, etim, ecs0, esum;
    int d, nreads;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      rd(3'(r), v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 rd_req reset", {31'b0, rd_req}, 32'h0);
    check("R1 done reset", {31'b0, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R7 R9
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, TIM_INIT);
      wr(3'd5, CS0_INIT);
      wr(3'd1, VECS[i].base);
      wr(3'd2, VECS[i].len);
      lat_cfg = int'(VECS[i].lat);
      served = 0; stab_err = 0; seq_err = 0;
      next_exp = VECS[i].base;
      wr(3'd0, {20'b0, VECS[i].dly, VECS[i].code, VECS[i].cal, 3'b101});
      wait_done();
      @(negedge clk);
      d = div_of(VECS[i].code);
      etim = TIM_INIT; ecs0 = CS0_INIT;
      if (VECS[i].cal) begin
        ecs0[11:8] = 4'(d);
        if (d >= 1 && d <= 5) etim[(d-1)*4 +: 4] = VECS[i].dly;
      end
      nreads = int'((VECS[i].len + 32'd3) / 32'd4);
      esum = '0;
      for (int k = 0; k < nreads; k++) esum = esum + word_at(VECS[i].base + 32'(4*k));
      rd(3'd5, v); check(VECS[i].cal ? "R2 cs0 clock field" : "R4 cs0 untouched", v, ecs0);
      rd(3'd4, v); check(VECS[i].cal ? "R3 timing nibble" : "R4 timing untouched", v, etim);
      rd(3'd3, v); check(VECS[i].len == 0 ? "R9 zero-length sum" : "R5 checksum", v, esum);
      check(VECS[i].len == 0 ? "R9 no reads" : "R5 read count", 32'(served), 32'(nreads));
      check("R5 address sequence", 32'(seq_err), 32'h0);
      rd(3'd1, v); check("R5 final address", v, VECS[i].base + 32'(4*nreads));
      rd(3'd2, v); check("R5 final length", v, 32'h0);
      check("R6 request held", 32'(stab_err), 32'h0);
      rd(3'd0, v); check("R7 done set, enable cleared", {v[31], v[0]}, 32'h2);
      check("R7 done port", {31'b0, done}, 32'h1);
    end

    // R7 done sticky then cleared by control write
    repeat (5) @(negedge clk);
    check("R7 done sticky", {31'b0, done}, 32'h1);
    wr(3'd0, 32'h0);
    check("R7 done cleared by write", {31'b0, done}, 32'h0);

    // R8 write direction blocks start
    wr(3'd4, TIM_INIT);
    wr(3'd2, 32'd8);
    served = 0;
    wr(3'd0, {20'b0, 4'h5, 4'd15, 4'b1111});
    repeat (20) @(negedge clk);
    check("R8 no reads", 32'(served), 32'h0);
    check("R8 no done", {31'b0, done}, 32'h0);
    rd(3'd4, v); check("R8 timing unchanged", v, TIM_INIT);
    rd(3'd2, v); check("R8 length kept", v, 32'd8);

    // R10 writes while busy are ignored
    wr(3'd4, TIM_INIT);
    wr(3'd5, CS0_INIT);
    wr(3'd1, 32'h0000_4000);
    wr(3'd2, 32'd16);
    lat_cfg = 6; served = 0; stab_err = 0; seq_err = 0; next_exp = 32'h0000_4000;
    wr(3'd0, {20'b0, 4'h2, 4'd6, 4'b1101});
    @(negedge clk);
    wr(3'd2, 32'd0);
    wr(3'd5, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0);
    wait_done();
    @(negedge clk);
    esum = '0;
    for (int k = 0; k < 4; k++) esum = esum + word_at(32'h0000_4000 + 32'(4*k));
    rd(3'd3, v); check("R10 sum after busy writes", v, esum);
    check("R10 read count", 32'(served), 32'd4);
    ecs0 = CS0_INIT; ecs0[11:8] = 4'd4;
    rd(3'd5, v); check("R10 cs0 after busy writes", v, ecs0);
    etim = TIM_INIT; etim[15:12] = 4'h2;
    rd(3'd4, v); check("R10 timing after busy writes", v, etim);
    check("R6 long latency hold", 32'(stab_err), 32'h0);

    report();
  end
endmodule